// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Programmable Almost Flag

This block buffers 18-bit words between two unrelated clock domains. A producer strobes words in on the write clock while the buffer is not full. A consumer sees the oldest stored word on its data output at all times, without issuing a read first. Each read strobe on the read clock drops that word and shows the next one. The default configuration holds 512 words.

Status is reported in both domains. The read side drives an active-low empty indication. The write side drives an active-low full indication, a half-full flag, and one combined almost flag. The almost flag is high when the buffer is nearly empty or nearly full. A single 8-bit offset sets both margins; it resets to 128. After reset, and before the first word is accepted, software may replace it from the low byte of the write data bus.

Top module: `dcfifo_fwft`

## Requirements
- R1: Words leave in the order they were accepted, and up to 512 words can be held at once. While `empty_n` is high and `rd_en` is low, `rd_data` holds its value.
- R2: The first word written into an empty buffer appears on `rd_data`, with `empty_n` high, within three read-clock edges and without any read strobe.
- R3: `empty_n` is low when the read side sees zero stored words and high otherwise. A read is accepted on a rising `rd_clk` edge only when `rd_en` is high and `empty_n` is high.
- R4: `full_n` is low when 512 words are stored and high otherwise. A write strobe while `full_n` is low is ignored and stores nothing.
- R5: A read strobe while `empty_n` is low is ignored and leaves the read position unchanged.
- R6: `half_full` is high when the write-side count is 256 or more, and low at 255 or fewer.
- R7: `almost` is high when the write-side count is at or below the offset, or at or above 512 minus the offset. It is low otherwise. The offset defaults to 128.
- R8: Between reset and the first accepted write, a rising `wr_clk` edge with `cfg_n` low and `wr_en` low loads `wr_data[7:0]` as the offset. The same offset is used for both margins.
- R9: After the first accepted write, the offset is frozen until the next reset.
- R10: While `rst_n` is low, and after it is released, the buffer is empty. At that point `empty_n` is 0, `full_n` is 1, `half_full` is 0 and `almost` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, sampled on rising `wr_clk` |
| cfg_n | input | 1 | Active-low offset load request (write domain) |
| wr_data | input | 18 | Write data; bits 7:0 also carry the offset value |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| half_full | output | 1 | High at 256 or more stored words (write domain) |
| almost | output | 1 | Almost-empty or almost-full indication (write domain) |
| rd_en | input | 1 | Read strobe, sampled on rising `rd_clk` |
| rd_data | output | 18 | Oldest stored word (fall-through) |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |

## Verification
The hardest state to reach from the ports is a full buffer that then receives further write strobes. The ignored strobes are only visible later, as corrupted or extra words during the drain. To reach it, the bench fills all 512 slots one word at a time. After each write it checks every write-side flag against a count it keeps itself. It then strobes writes against the full buffer and drains all 512 words against the computed pattern. The closed offset window is reached in a similar way. The bench programs an offset, accepts one word, and then attempts to load a second offset. A sweep of the almost flag over every count then shows which of the two offsets is in force.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int FIFO_DEPTH  = 512;
  localparam int FIFO_WIDTH  = 18;
  localparam int OFS_BITS    = 8;
  localparam int OFS_DEFAULT = 128;

  typedef struct packed {
    logic full_n;
    logic half_full;
    logic almost;
  } wr_flags_t;
endpackage

// File: rtl/afifo_rst_sync.sv
module afifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/afifo_wr_side.sv
module afifo_wr_side
  import afifo_pkg::*;
#(
  parameter int DEPTH   = FIFO_DEPTH,
  parameter int OFS_W   = OFS_BITS,
  parameter int DEF_OFS = OFS_DEFAULT,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             cfg_n,
  input  logic [OFS_W-1:0] cfg_val,
  input  logic [AW:0]      rgray_s,
  output wr_flags_t        flags,
  output logic [AW:0]      wptr,
  output logic [AW:0]      wgray,
  output logic             wr_go,
  output logic             prog_open,
  output logic [OFS_W-1:0] ofs
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [AW:0]      wptr_q, wptr_d;
  logic [AW:0]      wgray_q, wgray_d;
  logic             prog_q, prog_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [AW:0]      rbin;
  logic [CW-1:0]    count;
  logic [CW-1:0]    ofs_x;

  for (genvar i = 0; i <= AW; i++) begin : g_r2b
    assign rbin[i] = ^(rgray_s >> i);
  end

  assign count = wptr_q - rbin;
  assign ofs_x = CW'(ofs_q);

  always_comb begin
    flags.full_n    = (count != FULL_CNT);
    flags.half_full = (count >= HALF_CNT);
    flags.almost    = (count <= ofs_x) || (count >= (FULL_CNT - ofs_x));
  end

  always_comb begin
    wr_go   = wr_en & flags.full_n;
    wptr_d  = wr_go ? (wptr_q + 1'b1) : wptr_q;
    wgray_d = wptr_d ^ (wptr_d >> 1);
    prog_d  = prog_q & ~wr_go;
    ofs_d   = (prog_q & ~cfg_n & ~wr_en) ? cfg_val : ofs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      prog_q  <= 1'b1;
      ofs_q   <= OFS_W'(DEF_OFS);
    end else begin
      wptr_q  <= wptr_d;
      wgray_q <= wgray_d;
      prog_q  <= prog_d;
      ofs_q   <= ofs_d;
    end
  end

  assign wptr      = wptr_q;
  assign wgray     = wgray_q;
  assign prog_open = prog_q;
  assign ofs       = ofs_q;
endmodule

// File: rtl/afifo_rd_side.sv
module afifo_rd_side #(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic        empty_n,
  output logic        rd_go,
  output logic [AW:0] rptr,
  output logic [AW:0] rgray
);
  logic [AW:0] rptr_q, rptr_d;
  logic [AW:0] rgray_q, rgray_d;
  logic [AW:0] wbin;

  for (genvar i = 0; i <= AW; i++) begin : g_w2b
    assign wbin[i] = ^(wgray_s >> i);
  end

  always_comb begin
    empty_n = (rptr_q != wbin);
    rd_go   = rd_en & empty_n;
    rptr_d  = rd_go ? (rptr_q + 1'b1) : rptr_q;
    rgray_d = rptr_d ^ (rptr_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else begin
      rptr_q  <= rptr_d;
      rgray_q <= rgray_d;
    end
  end

  assign rptr  = rptr_q;
  assign rgray = rgray_q;
endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft
  import afifo_pkg::*;
#(
  parameter int DEPTH   = FIFO_DEPTH,
  parameter int WIDTH   = FIFO_WIDTH,
  parameter int OFS_W   = OFS_BITS,
  parameter int DEF_OFS = OFS_DEFAULT
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             cfg_n,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_n,
  output logic             half_full,
  output logic             almost,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n
);
  localparam int AW = $clog2(DEPTH);

  logic             wrst_n, rrst_n;
  logic [AW:0]      wptr, wgray, wgray_s;
  logic [AW:0]      rptr, rgray, rgray_s;
  logic             wr_go, rd_go, prog_open;
  logic [OFS_W-1:0] ofs;
  wr_flags_t        flags;
  logic [WIDTH-1:0] mem [DEPTH];

  afifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  afifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  afifo_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  afifo_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  afifo_wr_side #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .cfg_n(cfg_n),
    .cfg_val(wr_data[OFS_W-1:0]), .rgray_s(rgray_s), .flags(flags),
    .wptr(wptr), .wgray(wgray), .wr_go(wr_go), .prog_open(prog_open), .ofs(ofs)
  );

  afifo_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .empty_n(empty_n), .rd_go(rd_go), .rptr(rptr), .rgray(rgray)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_go) mem[wptr[AW-1:0]] <= wr_data;
  end

  assign rd_data   = mem[rptr[AW-1:0]];
  assign full_n    = flags.full_n;
  assign half_full = flags.half_full;
  assign almost    = flags.almost;
endmodule

// File: rtl/dcfifo_fwft_chk.sv
module dcfifo_fwft_chk #(
  parameter int AW = 9,
  parameter int W  = 18,
  parameter int OW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full_n,
  input logic          empty_n,
  input logic          half_full,
  input logic [W-1:0]  rd_data,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic          wr_go,
  input logic          prog_open,
  input logic [OW-1:0] ofs
);
  a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wptr));

  a_r5_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> $stable(rptr));

  a_r1_head_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (empty_n && !rd_en) |=> $stable(rd_data));

  a_r9_window_closes: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_go |=> !prog_open);

  a_r9_offset_frozen: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !prog_open |=> $stable(ofs));

  a_r6_full_is_half: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> half_full);
endmodule

bind dcfifo_fwft dcfifo_fwft_chk #(.AW(AW), .W(WIDTH), .OW(OFS_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full_n(full_n), .empty_n(empty_n), .half_full(half_full), .rd_data(rd_data),
  .wptr(wptr), .rptr(rptr), .wr_go(wr_go), .prog_open(prog_open), .ofs(ofs)
);

// File: tb/tb_dcfifo_fwft.sv
module tb_dcfifo_fwft;
  localparam int WR_T  = 10;
  localparam int RD_T  = 13;
  localparam int DEPTH = 512;

  logic        wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic        wr_en = 0, cfg_n = 1, rd_en = 0;
  logic [17:0] wr_data = '0;
  logic        full_n, half_full, almost, empty_n;
  logic [17:0] rd_data;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(WR_T/2) wr_clk = ~wr_clk;
  always #(RD_T/2) rd_clk = ~rd_clk;

  dcfifo_fwft dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_n(cfg_n),
    .wr_data(wr_data), .full_n(full_n), .half_full(half_full), .almost(almost),
    .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n)
  );

  function automatic logic [17:0] pat(int n);
    return 18'((n * 7919 + 3) ^ (n << 9));
  endfunction

  function automatic logic exp_alm(int c, int o);
    return (c <= o) || (c >= DEPTH - o);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; cfg_n = 1;
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
  endtask

  task automatic push(logic [17:0] d);
    @(negedge wr_clk); wr_en = 1; wr_data = d;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic wr_flags(int cnt, int o);
    chk("R6 half_full vs count", 32'(half_full), 32'(cnt >= DEPTH/2));
    chk("R7 almost vs count", 32'(almost), 32'(exp_alm(cnt, o)));
    chk("R4 full_n vs count", 32'(full_n), 32'(cnt != DEPTH));
  endtask

  task automatic pop(int k);
    @(negedge rd_clk);
    chk("R3 empty_n before pop", 32'(empty_n), 32'd1);
    chk("R1 order of words", 32'(rd_data), 32'(pat(k)));
    rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic drain_all();
    for (int k = 0; k < DEPTH; k++) pop(k);
    settle();
    chk("R3 empty_n after drain", 32'(empty_n), 32'd0);
    wr_flags(0, 0);
  endtask

  initial begin
    // Phase A: default offset
    do_reset();
    chk("R10 empty_n after reset", 32'(empty_n), 32'd0);
    chk("R10 full_n after reset", 32'(full_n), 32'd1);
    chk("R10 half_full after reset", 32'(half_full), 32'd0);
    chk("R10 almost after reset", 32'(almost), 32'd1);

    // R5: read strobes while empty must not move the read position
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk); rd_en = 0;
    chk("R5 empty_n after ignored reads", 32'(empty_n), 32'd0);

    for (int n = 0; n < DEPTH; n++) begin
      push(pat(n));
      if (n == 0) begin
        repeat (3) @(negedge rd_clk);
        chk("R2 fall-through empty_n", 32'(empty_n), 32'd1);
        chk("R2 fall-through data", 32'(rd_data), 32'(pat(0)));
      end
      wr_flags(n + 1, 128);
    end

    // R4: writes against a full buffer
    for (int n = 0; n < 4; n++) push(18'h3FFFF);
    chk("R4 full_n held after ignored writes", 32'(full_n), 32'd0);
    settle();
    drain_all();   // R1 and R4: exactly 512 words, in order, no extras
    // an extra pop must be refused: buffer is empty again
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    push(18'h1234);
    repeat (4) @(negedge rd_clk);
    chk("R5 data after ignored read", 32'(rd_data), 32'h1234);

    // Phase B: programmed offset 40, later attempt ignored
    do_reset();
    @(negedge wr_clk); cfg_n = 0; wr_data = 18'd40;
    @(negedge wr_clk); cfg_n = 1;
    chk("R8 almost at count 0 after load", 32'(almost), 32'd1);
    push(pat(0));
    @(negedge wr_clk); cfg_n = 0; wr_data = 18'd200;
    @(negedge wr_clk); cfg_n = 1;
    wr_flags(1, 40);
    for (int n = 1; n < DEPTH; n++) begin
      push(pat(n));
      // R8 and R9: offset 40 must govern, not 200
      wr_flags(n + 1, 40);
    end
    settle();
    drain_all();

    // Phase C: reset reopens window, default restored
    do_reset();
    chk("R10 almost after second reset", 32'(almost), 32'd1);
    for (int n = 0; n < 130; n++) push(pat(n));
    chk("R7 default offset at 130", 32'(almost), 32'(exp_alm(130, 128)));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(WR_T * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule